// File: doc/BRIEF.md
# Indexed Codec Control Register Interface

This block is the host-facing control front end of an audio codec. A host reaches it through four byte-wide direct ports, selected by a two-bit address: a pointer port, a window port that reads and writes the indirect register the pointer selects, a status port, and a programmed-I/O data port. Behind the window sit up to 32 indirect 8-bit control registers. Each has its own reset value, and some of them have special write rules.

The block enforces the update rules of the indirect bank. The playback data-format register can be written only while a mode-change-enable flag is set. Some registers are read-only or reserved. The mode register has only one writable bit. The interface configuration register has a bit that is always zero. The block also owns the interrupt request. A one-cycle pulse from the playback transfer counter raises it. The host lowers it by writing the status port, or by dropping the playback-pending bit in the alternate status register. The current data-format register is driven out continuously for the audio path.

Top module: `codec_regif`

## Requirements
- R1: After reset the pointer port reads 0x40 and the status port reads 0x00. The indirect registers read back these values: 2,3,4,5,18,19 give 0x88; 6,7 give 0x80; 9 gives 0x08; 12 gives 0x8A; 25,26 give 0xA0; all others give 0x00.
- R2: Bit 7 of the pointer port always reads 0, whatever value was written.
- R3: The indirect register number is pointer bits [3:0] while bit 6 of register 12 (wide mode) is 0, and pointer bits [4:0] while it is 1.
- R4: A write to register 8 (format) with pointer bit 6 (change enable) set stores all 8 bits, and `fmt_out` shows the new value on the next cycle.
- R5: With pointer bit 6 clear and bit 0 of register 24 (partial change enable) set, a format write updates only bits [7:4] and keeps bits [3:0].
- R6: With both enables clear, a format write leaves the register unchanged.
- R7: Bit 5 of register 9 is always stored as 0.
- R8: Register 11 is read-only. Writes to it have no effect.
- R9: A write to register 12 changes only its bit 6.
- R10: Registers 22, 27 and 29 are reserved. They read 0 and ignore writes.
- R11: A `pb_done` pulse sets status bit 0 and bit 4 of register 24 (playback pending), and raises `irq` on the next cycle. Any write to the status port clears status bit 0 and bits 4, 5 and 6 of register 24, and lowers `irq`.
- R12: An indirect write that changes bit 4 of register 24 from 1 to 0 lowers `irq` and clears status bit 0. A write that leaves the bit at 1 does not.
- R13: When `pb_done` and a clear arrive in the same cycle, the set wins and `irq` stays high.
- R14: The programmed-I/O port (address 3) reads 0x00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the direct port selected by `bus_addr` |
| bus_addr | input | 2 | Direct port select: 0 pointer, 1 window, 2 status, 3 programmed-I/O |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected port (combinational) |
| pb_done | input | 1 | One-cycle pulse from the playback counter requesting an interrupt |
| fmt_out | output | 8 | Current playback data-format register |
| irq | output | 1 | Registered interrupt request, equal to status bit 0 |

## Verification
The bench aims at the index-width switch by using pointer value 0x16. It lands on a DAC control register (0x80) in narrow mode and on a reserved register (0x00) in wide mode, so a decoder that ignored the mode bit would return the wrong byte. The partial format update uses old and new values whose nibbles differ, so keeping the wrong half shows up at once. The interrupt tests cover a write to register 24 that keeps the pending bit set, which must not clear the line. They also cover a set and a clear in the same cycle, where a design with the wrong priority would drop `irq`. Reads of the read-only, reserved and mode registers after writes of all-ones catch any missing write mask.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

    localparam int DW      = 8;
    localparam int NREG    = 32;
    localparam int IDX_W   = $clog2(NREG);

    typedef enum logic [1:0] {
        PORT_PTR    = 2'd0,
        PORT_WIN    = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_PIO    = 2'd3
    } port_e;

    // indirect register numbers with special behaviour
    localparam int REG_FMT     = 8;
    localparam int REG_IFCFG   = 9;
    localparam int REG_ERRSTAT = 11;
    localparam int REG_MODE    = 12;
    localparam int REG_ALTSTAT = 24;

    // bit positions
    localparam int PTR_CHG_BIT  = 6;
    localparam int MODE_WIDE_BIT = 6;
    localparam int IFCFG_RSV_BIT = 5;
    localparam int ALT_PCHG_BIT  = 0;
    localparam int ALT_PB_BIT    = 4;
    localparam int ALT_CAP_BIT   = 5;
    localparam int ALT_TMR_BIT   = 6;
    localparam int STAT_INT_BIT  = 0;

    localparam logic [DW-1:0] PTR_RESET = 8'h40;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    val;
        logic             pb_drop;
    } wr_req_t;

    function automatic logic [DW-1:0] reg_reset_value(input int unsigned n);
        case (n)
            2, 3, 4, 5, 18, 19: reg_reset_value = 8'h88;
            6, 7:               reg_reset_value = 8'h80;
            9:                  reg_reset_value = 8'h08;
            12:                 reg_reset_value = 8'h8A;
            25, 26:             reg_reset_value = 8'hA0;
            default:            reg_reset_value = 8'h00;
        endcase
    endfunction

    function automatic logic reg_is_reserved(input int unsigned n);
        reg_is_reserved = (n == 22) || (n == 27) || (n == 29);
    endfunction

endpackage

// File: rtl/codec_idx_sel.sv
module codec_idx_sel
    import codec_regif_pkg::*;
#(
    parameter int NARROW_W = 4
) (
    input  logic [DW-1:0]    ptr,
    input  logic             wide,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] NARROW_MASK = IDX_W'((1 << NARROW_W) - 1);

    always_comb begin
        if (wide)
            idx = ptr[IDX_W-1:0];
        else
            idx = ptr[IDX_W-1:0] & NARROW_MASK;
    end
endmodule

// File: rtl/codec_wr_shaper.sv
module codec_wr_shaper
    import codec_regif_pkg::*;
(
    input  logic             win_wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    cur,
    input  logic             chg_en,
    input  logic             pchg_en,
    output wr_req_t          req
);
    always_comb begin
        req.idx     = idx;
        req.val     = wdata;
        req.we      = win_wr;
        req.pb_drop = 1'b0;
        if (reg_is_reserved(32'(idx))) begin
            req.we = 1'b0;
        end else begin
            case (32'(idx))
                REG_FMT: begin
                    if (chg_en)
                        req.val = wdata;
                    else if (pchg_en)
                        req.val = {wdata[7:4], cur[3:0]};
                    else
                        req.we = 1'b0;
                end
                REG_IFCFG:   req.val[IFCFG_RSV_BIT] = 1'b0;
                REG_ERRSTAT: req.we = 1'b0;
                REG_MODE: begin
                    req.val = cur;
                    req.val[MODE_WIDE_BIT] = wdata[MODE_WIDE_BIT];
                end
                REG_ALTSTAT:
                    req.pb_drop = win_wr && cur[ALT_PB_BIT] && !wdata[ALT_PB_BIT];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
    import codec_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  logic             ack_clr,
    input  logic             pb_set,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_val,
    output logic [DW-1:0]    fmt,
    output logic             wide,
    output logic             pchg_en
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] RV = reg_reset_value(g);
        logic hit;
        assign hit = req.we && (req.idx == IDX_W'(g));
        if (g == REG_ALTSTAT) begin : g_alt
            logic [DW-1:0] nxt;
            always_comb begin
                nxt = hit ? req.val : regs[g];
                if (ack_clr) begin
                    nxt[ALT_PB_BIT]  = 1'b0;
                    nxt[ALT_CAP_BIT] = 1'b0;
                    nxt[ALT_TMR_BIT] = 1'b0;
                end
                if (pb_set)
                    nxt[ALT_PB_BIT] = 1'b1;
            end
            always_ff @(posedge clk) begin
                if (rst) regs[g] <= RV;
                else     regs[g] <= nxt;
            end
        end else if (reg_is_reserved(g)) begin : g_rsv
            always_ff @(posedge clk) regs[g] <= '0;
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)      regs[g] <= RV;
                else if (hit) regs[g] <= req.val;
            end
        end
    end

    assign rd_val  = regs[rd_idx];
    assign fmt     = regs[REG_FMT];
    assign wide    = regs[REG_MODE][MODE_WIDE_BIT];
    assign pchg_en = regs[REG_ALTSTAT][ALT_PCHG_BIT];

    p_errstat_ro_r8: assert property (@(posedge clk) disable iff (rst)
        $stable(regs[REG_ERRSTAT]));
    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
        regs[22] == '0 && regs[27] == '0 && regs[29] == '0);
    p_mode_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        (regs[REG_MODE] & 8'hBF) == 8'h8A);
    p_ifcfg_rsv_r7: assert property (@(posedge clk) disable iff (rst)
        !regs[REG_IFCFG][IFCFG_RSV_BIT]);
    p_pb_set_r11: assert property (@(posedge clk) disable iff (rst)
        pb_set |=> regs[REG_ALTSTAT][ALT_PB_BIT]);
endmodule

// File: rtl/codec_regif.sv
module codec_regif
    import codec_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pb_done,
    output logic [7:0] fmt_out,
    output logic       irq
);
    logic [DW-1:0]    ptr_q;
    logic             int_q, int_d, irq_q;
    logic [IDX_W-1:0] idx;
    logic             wide, pchg_en;
    logic [DW-1:0]    cur_val;
    wr_req_t          req;
    logic             ptr_wr, win_wr, stat_wr, int_clr;

    assign ptr_wr  = bus_wr && (port_e'(bus_addr) == PORT_PTR);
    assign win_wr  = bus_wr && (port_e'(bus_addr) == PORT_WIN);
    assign stat_wr = bus_wr && (port_e'(bus_addr) == PORT_STATUS);

    codec_idx_sel #(.NARROW_W(4)) u_idx (
        .ptr  (ptr_q),
        .wide (wide),
        .idx  (idx)
    );

    codec_wr_shaper u_shape (
        .win_wr  (win_wr),
        .idx     (idx),
        .wdata   (bus_wdata),
        .cur     (cur_val),
        .chg_en  (ptr_q[PTR_CHG_BIT]),
        .pchg_en (pchg_en),
        .req     (req)
    );

    codec_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .ack_clr (stat_wr),
        .pb_set  (pb_done),
        .rd_idx  (idx),
        .rd_val  (cur_val),
        .fmt     (fmt_out),
        .wide    (wide),
        .pchg_en (pchg_en)
    );

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= PTR_RESET;
        else if (ptr_wr) ptr_q <= {1'b0, bus_wdata[DW-2:0]};
    end

    assign int_clr = stat_wr || req.pb_drop;

    always_comb begin
        int_d = int_q;
        if (int_clr) int_d = 1'b0;
        if (pb_done) int_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            int_q <= int_d;
            irq_q <= int_d;
        end
    end
    assign irq = irq_q;

    always_comb begin
        case (port_e'(bus_addr))
            PORT_PTR:    bus_rdata = {1'b0, ptr_q[DW-2:0]};
            PORT_WIN:    bus_rdata = cur_val;
            PORT_STATUS: begin
                bus_rdata = '0;
                bus_rdata[STAT_INT_BIT] = int_q;
            end
            default:     bus_rdata = '0;
        endcase
    end

    p_irq_tracks_int_r11: assert property (@(posedge clk) disable iff (rst)
        irq == int_q);
    p_ptr_msb_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> !bus_rdata[7]);
    p_set_wins_r13: assert property (@(posedge clk) disable iff (rst)
        pb_done |=> irq);
    p_ack_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !pb_done) |=> !irq);
    p_fmt_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (win_wr && idx == IDX_W'(REG_FMT) && !ptr_q[PTR_CHG_BIT] && !pchg_en)
        |=> $stable(fmt_out));
endmodule

// File: tb/codec_regif_bench.sv
module codec_regif_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       pb_done;
    logic [7:0] fmt_out;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    codec_regif u_codec_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pb_done   (pb_done),
        .fmt_out   (fmt_out),
        .irq       (irq)
    );

    function automatic logic [7:0] exp_reset(input int n);
        if (n == 2 || n == 3 || n == 4 || n == 5 || n == 18 || n == 19) return 8'h88;
        if (n == 6 || n == 7) return 8'h80;
        if (n == 9) return 8'h08;
        if (n == 12) return 8'h8A;
        if (n == 25 || n == 26) return 8'hA0;
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ind_wr(input logic [7:0] p, input logic [7:0] d);
        wr(2'd0, p);
        wr(2'd1, d);
    endtask

    task automatic ind_rd(input logic [7:0] p, output logic [7:0] d);
        wr(2'd0, p);
        rd(2'd1, d);
    endtask

    task automatic pulse_pb();
        @(negedge clk);
        pb_done = 1'b1;
        @(negedge clk);
        pb_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 pointer reset", v, 8'h40);
        rd(2'd2, v); check("R1 status reset", v, 8'h00);
        check("R1 irq reset", {7'd0, irq}, 8'h00);
        for (int i = 0; i < 16; i++) begin
            ind_rd(8'(i), v); check($sformatf("R1 reg %0d", i), v, exp_reset(i));
        end
        ind_wr(8'h0C, 8'h40);
        for (int i = 16; i < 32; i++) begin
            ind_rd(8'(i), v); check($sformatf("R1 reg %0d", i), v, exp_reset(i));
        end
    endtask

    task automatic t_ptr_msb();
        logic [7:0] v;
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 pointer bit7", v, 8'h7F);
    endtask

    task automatic t_width();
        logic [7:0] v;
        ind_wr(8'h0C, 8'h00);
        ind_rd(8'h16, v); check("R3 narrow index", v, 8'h80);
        ind_wr(8'h0C, 8'h40);
        ind_rd(8'h16, v); check("R3 wide index", v, 8'h00);
    endtask

    task automatic t_format();
        ind_wr(8'h48, 8'h5A);
        check("R4 format with change enable", fmt_out, 8'h5A);
        ind_wr(8'h18, 8'h01);
        ind_wr(8'h08, 8'h3C);
        check("R5 partial format update", fmt_out, 8'h3A);
        ind_wr(8'h18, 8'h00);
        ind_wr(8'h08, 8'hFF);
        check("R6 format write blocked", fmt_out, 8'h3A);
    endtask

    task automatic t_masks();
        logic [7:0] v;
        ind_wr(8'h09, 8'hFF); ind_rd(8'h09, v); check("R7 ifcfg bit5", v, 8'hDF);
        ind_wr(8'h0B, 8'hFF); ind_rd(8'h0B, v); check("R8 read-only reg", v, 8'h00);
        ind_wr(8'h0C, 8'h00); ind_rd(8'h0C, v); check("R9 mode write 00", v, 8'h8A);
        ind_wr(8'h0C, 8'hFF); ind_rd(8'h0C, v); check("R9 mode write FF", v, 8'hCA);
        ind_wr(8'h16, 8'hFF); ind_rd(8'h16, v); check("R10 reserved 22", v, 8'h00);
        ind_wr(8'h1D, 8'hFF); ind_rd(8'h1D, v); check("R10 reserved 29", v, 8'h00);
        wr(2'd3, 8'hFF); rd(2'd3, v); check("R14 pio port", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(2'd0, 8'h18);
        pulse_pb();
        check("R11 irq raised", {7'd0, irq}, 8'h01);
        rd(2'd2, v); check("R11 status int set", v, 8'h01);
        rd(2'd1, v); check("R11 pending bit set", v, 8'h10);
        ind_wr(8'h18, 8'h70);
        wr(2'd2, 8'h00);
        check("R11 irq cleared by ack", {7'd0, irq}, 8'h00);
        rd(2'd2, v); check("R11 status int cleared", v, 8'h00);
        rd(2'd1, v); check("R11 pending bits cleared", v, 8'h00);
        pulse_pb();
        ind_wr(8'h18, 8'h10);
        check("R12 pending kept, irq stays", {7'd0, irq}, 8'h01);
        ind_wr(8'h18, 8'h00);
        check("R12 pending dropped, irq low", {7'd0, irq}, 8'h00);
        rd(2'd2, v); check("R12 status int cleared", v, 8'h00);
        @(negedge clk);
        pb_done = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h00;
        @(negedge clk);
        pb_done = 1'b0; bus_wr = 1'b0;
        check("R13 set beats clear", {7'd0, irq}, 8'h01);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00; pb_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ptr_msb();
        t_width();
        t_format();
        t_masks();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule